// File: doc/BRIEF.md
# Flash Indirect Write Launch Register

This block is the single 32-bit control and status word that software uses to drive a serial-flash indirect write engine. A write to the word can launch a new operation, abort everything outstanding, or acknowledge completed work. A read returns progress: whether work is outstanding, whether the two-entry launch queue is full, whether the data buffer reports full, a sticky completion flag, and a 2-bit count of completions since the last acknowledge.

The block sits between a plain register bus (address, write enable, write data, combinational read data) and an abstract transfer engine. It keeps up to two launched operations pending. When an operation is pending and has not yet been handed out, and the engine is idle, the block gives the engine a one-cycle launch pulse. A one-cycle done pulse from the engine retires the head operation. An abort write flushes the queue and sends the engine a one-cycle cancel pulse. The start address and byte count are held in other registers and are assumed to be already programmed.

Top module: `flash_wr_launch_csr`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the read word is all zeros, and `engLaunch` and `engCancel` are low.
- R2: A write of 1 in bit 0 at `CSR_OFFSET` adds one pending operation, unless the queue already holds two. From the next cycle, bit 2 reads 1 while at least one operation is pending, and bit 4 reads 1 while exactly two are pending. Writing 0 to bit 0 adds nothing.
- R3: A start written while two operations are pending is ignored. Bit 4 stays 1 and the pending count stays at two.
- R4: When an operation is pending, has not yet been handed out, and `engBusy` is low, `engLaunch` pulses high for exactly one cycle in the next cycle. Each pending operation is handed out once.
- R5: A write of 1 in bit 1 empties the queue from the next cycle and raises `engCancel` for one cycle. If bit 0 is 1 in the same write, nothing is queued or launched.
- R6: An `engDone` pulse while the queue is not empty removes the head entry. From the next cycle, bit 5 reads 1 and bits 7:6 have advanced by one, modulo 4.
- R7: A write of 1 in bit 5 clears both bit 5 and bits 7:6. A completion in the same cycle still counts, leaving bit 5 at 1 and bits 7:6 at 1.
- R8: Bit 3 reads the current level of `sramFullIn` with no delay.
- R9: Bits 1:0 and 31:8 always read 0. A read at any other address returns 0, and a write at any other address changes nothing.
- R10: An `engDone` pulse while the queue is empty is ignored. Bit 5, bits 7:6 and the pending count are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register bus address |
| regWe | input | 1 | Register bus write enable |
| regWdata | input | DATA_W | Register bus write data |
| regRdata | output | DATA_W | Register bus read data, combinational |
| sramFullIn | input | 1 | Data buffer full indication |
| engBusy | input | 1 | Engine is running an operation |
| engDone | input | 1 | One-cycle engine completion pulse |
| engLaunch | output | 1 | One-cycle request to start the head operation |
| engCancel | output | 1 | One-cycle request to abort all work |

## Verification
Status fields driven by a bus write or a done pulse change at the clock edge that samples them, so they are due on the read word one cycle after the stimulus. Bit 3 and the address decode of the read word are combinational and follow their inputs within the same cycle. `engCancel` is registered and appears one cycle after the abort write. `engLaunch` appears one cycle after the queue holds an entry that has not been handed out, which makes it two cycles after a start write into an empty queue. The bench reference model advances on each rising edge and compares every field and both engine pulses a quarter period later, so each result is checked in exactly the cycle it is due.

// File: rtl/flash_wr_csr_pkg.sv
package flash_wr_csr_pkg;
  // Bit positions within the control/status word
  localparam int BitGo      = 0;
  localparam int BitAbort   = 1;
  localparam int BitActive  = 2;
  localparam int BitBufFull = 3;
  localparam int BitQFull   = 4;
  localparam int BitDone    = 5;
  localparam int DoneCntLo  = 6;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic push;     // queue one operation
    logic flush;    // abort everything
    logic clrDone;  // acknowledge completions
  } strobe_t;
endpackage

// File: rtl/flash_wr_csr_ctrl.sv
module flash_wr_csr_ctrl
  import flash_wr_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CSR_OFFSET = 8'h70,
  parameter int OCC_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [OCC_W-1:0]  occ,
  input  logic              engBusy,
  input  logic              engDone,
  output strobe_t           strb,
  output logic              engLaunch,
  output logic              engCancel
);
  logic hit, goReq, abortReq, doneEv, issueNow, headIssued;
  logic unusedWdata;

  assign hit      = regWe && (regAddr == CSR_OFFSET);
  assign goReq    = hit && regWdata[BitGo];
  assign abortReq = hit && regWdata[BitAbort];
  assign unusedWdata = ^regWdata;

  always_comb begin
    strb         = '0;
    strb.flush   = abortReq;
    strb.push    = goReq && !abortReq;   // abort beats start
    strb.clrDone = hit && regWdata[BitDone];
  end

  assign doneEv   = engDone && (occ != '0);
  assign issueNow = (occ != '0) && !headIssued && !engBusy && !abortReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headIssued <= 1'b0;
      engLaunch  <= 1'b0;
      engCancel  <= 1'b0;
    end else begin
      engLaunch <= issueNow;
      engCancel <= abortReq;
      if (abortReq)      headIssued <= 1'b0;
      else if (issueNow) headIssued <= 1'b1;
      else if (doneEv)   headIssued <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_wr_csr_dp.sv
module flash_wr_csr_dp
  import flash_wr_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  parameter int OCC_W  = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              engDone,
  input  logic              sramFullIn,
  output logic [OCC_W-1:0]  occ,
  output logic [DATA_W-1:0] csrWord
);
  localparam logic [OCC_W-1:0] OccFull = OCC_W'(DEPTH);

  logic             doneFlag;
  logic [CNT_W-1:0] doneCnt;
  logic             doneEv, pushOk;
  logic [OCC_W-1:0] occNext;

  assign doneEv = engDone && (occ != '0);
  assign pushOk = strb.push && (occ != OccFull);

  always_comb begin
    occNext = occ;
    if (doneEv) occNext = occNext - OCC_W'(1);
    if (pushOk) occNext = occNext + OCC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ      <= '0;
      doneFlag <= 1'b0;
      doneCnt  <= '0;
    end else begin
      occ      <= strb.flush ? '0 : occNext;
      doneFlag <= (strb.clrDone ? 1'b0 : doneFlag) | doneEv;
      doneCnt  <= (strb.clrDone ? '0 : doneCnt) + CNT_W'(doneEv);
    end
  end

  always_comb begin
    csrWord = '0;
    csrWord[BitActive]  = (occ != '0);
    csrWord[BitBufFull] = sramFullIn;
    csrWord[BitQFull]   = (occ == OccFull);
    csrWord[BitDone]    = doneFlag;
    for (int i = 0; i < CNT_W; i++) csrWord[DoneCntLo + i] = doneCnt[i];
  end
endmodule

// File: rtl/flash_wr_launch_csr.sv
module flash_wr_launch_csr
  import flash_wr_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CSR_OFFSET = 8'h70,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sramFullIn,
  input  logic              engBusy,
  input  logic              engDone,
  output logic              engLaunch,
  output logic              engCancel
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  strobe_t           strb;
  logic [OCC_W-1:0]  occ;
  logic [DATA_W-1:0] csrWord;

  flash_wr_csr_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_OFFSET(CSR_OFFSET), .OCC_W(OCC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .occ(occ), .engBusy(engBusy), .engDone(engDone),
    .strb(strb), .engLaunch(engLaunch), .engCancel(engCancel)
  );

  flash_wr_csr_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .OCC_W(OCC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .engDone(engDone),
    .sramFullIn(sramFullIn), .occ(occ), .csrWord(csrWord)
  );

  assign regRdata = (regAddr == CSR_OFFSET) ? csrWord : '0;
endmodule

// File: rtl/flash_wr_csr_chk.sv
module flash_wr_csr_chk
  import flash_wr_csr_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int OCC_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [OCC_W-1:0] occ,
  input strobe_t          strb,
  input logic             engDone,
  input logic             engLaunch,
  input logic             engCancel
);
  a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(DEPTH) && !strb.flush && !engDone) |=> occ == OCC_W'(DEPTH));

  a_r4_launch_single: assert property (@(posedge clk) disable iff (!rstN)
    engLaunch |=> !engLaunch);

  a_r5_cancel_flushed: assert property (@(posedge clk) disable iff (!rstN)
    engCancel |-> occ == '0);

  a_r6_done_pops: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && occ != '0 && !strb.flush && !strb.push) |=> occ == $past(occ) - OCC_W'(1));
endmodule

bind flash_wr_launch_csr flash_wr_csr_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rstN(rstN), .occ(occ), .strb(strb), .engDone(engDone),
  .engLaunch(engLaunch), .engCancel(engCancel)
);

// File: tb/flash_wr_launch_csr_bench.sv
module flash_wr_launch_csr_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFF = 8'h70;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rstN = 0;
  logic [7:0] regAddr = OFF;
  logic regWe = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic sramFullIn = 0, engBusy = 0, engDone = 0;
  logic engLaunch, engCancel;

  int tests = 0, fails = 0, cyc = 0, engLat = 4, latLeft = 0;
  bit forceDone = 0, finished = 0;

  // behavioural reference state
  int mOcc = 0, mCnt = 0;
  bit mIssued = 0, mFlag = 0, mLaunch = 0, mCancel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wr_launch_csr u_flash_wr_launch_csr (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .sramFullIn(sramFullIn),
    .engBusy(engBusy), .engDone(engDone), .engLaunch(engLaunch),
    .engCancel(engCancel)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // reference model: advances on each rising edge from the inputs held across it
  task automatic modelStep();
    bit wr, go, ab, clr, doneEv, issue;
    if (!rstN) begin
      mOcc = 0; mCnt = 0; mIssued = 0; mFlag = 0; mLaunch = 0; mCancel = 0;
      return;
    end
    wr  = regWe && regAddr == OFF;          // R9: other addresses ignored
    go  = wr && regWdata[0];
    ab  = wr && regWdata[1];
    clr = wr && regWdata[5];
    doneEv = engDone && mOcc > 0;            // R10: done on empty ignored
    issue  = mOcc > 0 && !mIssued && !engBusy && !ab;
    mLaunch = issue;
    mCancel = ab;
    if (ab) mIssued = 0;
    else if (issue) mIssued = 1;
    else if (doneEv) mIssued = 0;
    if (ab) mOcc = 0;                        // R5: abort wins over start
    else begin
      int o = mOcc;
      if (doneEv) o--;
      if (go && mOcc < 2) o++;               // R3: start on full queue ignored
      mOcc = o;
    end
    if (clr) begin mFlag = 0; mCnt = 0; end  // R7
    if (doneEv) begin mFlag = 1; mCnt = (mCnt + 1) % 4; end
  endtask

  task automatic compareAll();
    string tg;
    bit onReg;
    onReg = (regAddr == OFF);
    tg = rstN ? "" : "R1 ";
    check({tg, "R2"}, "active bit2", int'(regRdata[2]), onReg ? int'(mOcc > 0) : 0);
    check({tg, "R2 R3"}, "queue-full bit4", int'(regRdata[4]), onReg ? int'(mOcc == 2) : 0);
    check({tg, "R8"}, "buffer-full bit3", int'(regRdata[3]), onReg ? int'(sramFullIn) : 0);
    check({tg, "R6 R7 R10"}, "done flag bit5", int'(regRdata[5]), onReg ? int'(mFlag) : 0);
    check({tg, "R6 R7 R10"}, "done count 7:6", int'(regRdata[7:6]), onReg ? mCnt : 0);
    check({tg, "R9"}, "zero bits", int'({regRdata[31:8], regRdata[1:0]}), 0);
    check({tg, "R4"}, "engLaunch", int'(engLaunch), int'(mLaunch));
    check({tg, "R5"}, "engCancel", int'(engCancel), int'(mCancel));
  endtask

  always @(posedge clk) begin
    cyc++;
    modelStep();
    #(CLK_PERIOD/4);
    if (!finished) compareAll();
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL all: watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      summary();
    end
  end

  // abstract engine: busy for engLat cycles after a launch, then one done pulse
  always @(negedge clk) begin
    engDone = 0;
    if (!rstN) begin engBusy = 0; latLeft = 0; end
    else if (engCancel) engBusy = 0;
    else if (engLaunch) begin engBusy = 1; latLeft = engLat; end
    else if (engBusy) begin
      if (latLeft == 0) begin engBusy = 0; engDone = 1; end
      else latLeft--;
    end
    if (forceDone) engDone = 1;
  end

  task automatic csrWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1; regWdata = d;
    @(negedge clk);
    regWe = 0; regWdata = 0; regAddr = OFF;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    idle(3);
    rstN = 1;                               // R1 checked during and after reset
    idle(2);
    sramFullIn = 1; idle(2); sramFullIn = 0; // R8
    csrWrite(OFF, 32'h1); idle(15);          // R2 R4 R6 single operation
    csrWrite(OFF, 32'h0); idle(3);           // R2 writing 0 adds nothing
    csrWrite(OFF, 32'h1); csrWrite(OFF, 32'h1); csrWrite(OFF, 32'h1); // R3
    idle(30);
    csrWrite(OFF, 32'h20); idle(3);          // R7 acknowledge
    for (int i = 0; i < 5; i++) begin csrWrite(OFF, 32'h1); idle(9); end // R6 wrap
    csrWrite(OFF, 32'h3); idle(5);           // R5 abort with start
    engLat = 30;
    csrWrite(OFF, 32'h1); csrWrite(OFF, 32'h1); idle(5);
    csrWrite(OFF, 32'h2); idle(5);           // R5 abort while busy and full
    engLat = 3;
    @(posedge clk); forceDone = 1; @(posedge clk); forceDone = 0; idle(3); // R10
    csrWrite(OFF + 8'h4, 32'h21);            // R9 write elsewhere
    regAddr = OFF + 8'h4; idle(3); regAddr = OFF; idle(3);
    lfsr = 32'h1d2c;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      engLat = (lfsr >> 4) % 6;
      sramFullIn = lfsr[9];
      case ((lfsr >> 12) % 8)
        0, 1, 2: csrWrite(OFF, 32'h1);
        3:       csrWrite(OFF, 32'h20);
        4:       csrWrite(OFF, 32'h21);
        5:       if (lfsr[15]) csrWrite(OFF, 32'h2); else idle(1);
        default: idle(1 + lfsr[17:16]);
      endcase
    end
    idle(60);
    finished = 1;
    summary();
  end
endmodule